// File: doc/BRIEF.md
# Learning Threshold Spiking Neuron

This block models a single neuron with a small, parameterised set of weighted input synapses. Input 0 is the gating (master) input and the others are subordinate inputs. A one-cycle `tick` strobe marks each 1 ms time step. On a tick, the neuron samples its spike inputs. The subordinate inputs can first be passed through a per-neuron delay of a programmable number of steps. If the gating input spiked, a short sequencer then walks the synapses one per clock. It sums the weights of the connected synapses, and separately the weights of the connected synapses that spiked.

The neuron fires when the spiking share is strictly above nine tenths of the connected total. After a fire, it strengthens the synapses that took part and weakens the connected ones that stayed silent. A synapse whose weight falls below a programmable floor is dropped from the neuron. A connect request brings a synapse back with a programmable starting weight, at any cycle and without disturbing the tick cadence. The last pair of sums is presented on debug outputs.

Top module: `spiking_neuron_core`

## Requirements
- R1: After reset, `fire` and `busy` are 0, both debug sums are 0 and every synapse is disconnected with weight 0. A tick with the gating input spiking then yields no fire and a connected total of 0.
- R2: A tick on which `spike_in[0]` is 0 starts no evaluation. `busy` stays 0, no fire is issued and both debug sums keep their previous values.
- R3: An evaluation fires exactly when 10 × (sum of weights of connected synapses that spiked) > 9 × (sum of weights of all connected synapses). A share of exactly nine tenths does not fire.
- R4: An evaluation raises `busy` from the clock edge that samples the tick. With the default of 4 synapses, `fire` is a single-cycle pulse that is high in the fifth cycle after that edge. `busy` returns to 0 within 2 × N_SYN + 2 cycles, before the next tick.
- R5: After a fire, each connected synapse that spiked gains INC_STEP (default 64) and each connected synapse that did not spike loses DEC_STEP (default 32). No weight changes when the neuron does not fire.
- R6: A weight increase saturates at 65535 and a weight decrease saturates at 0.
- R7: A synapse whose weight after a decrease is below `disc_level` becomes disconnected. It then contributes to neither sum.
- R8: A one-cycle `conn_req` with index `conn_idx` marks that synapse connected and loads `conn_weight` as its weight. It works again on a synapse that was disconnected earlier.
- R9: A connect request in the same cycle as the learning write to the same synapse overrides that write.
- R10: When `slave_delay` = D (0..DLY_MAX), the subordinate inputs `spike_in[N_SYN-1:1]` are evaluated with the values they had D ticks earlier. The gating input `spike_in[0]` is never delayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle time-step strobe |
| spike_in | input | N_SYN | Spike inputs; bit 0 is the gating synapse |
| slave_delay | input | DLYW | Delay in ticks applied to subordinate inputs |
| disc_level | input | W | Weight floor below which a synapse is dropped |
| conn_req | input | 1 | Connect request strobe |
| conn_idx | input | IDXW | Synapse index for a connect request |
| conn_weight | input | W | Initial weight loaded on connect |
| fire | output | 1 | One-cycle fire pulse |
| busy | output | 1 | Evaluation sequence in progress |
| dbg_fired_sum | output | SUMW | Last computed sum of spiking connected weights |
| dbg_total_sum | output | SUMW | Last computed sum of connected weights |

## Verification
The bench puts a share of exactly nine tenths against one a single unit above it. A design that compared with `>=` or truncated a percentage would fire on the first. Saturation is exercised at both ends. A weight near full scale that wrapped would report a tiny fired sum, and a small weight that underflowed would inflate the connected total. A connect request is timed onto the very cycle the learning update writes the same synapse; a wrong priority leaves the learnt weight, or a weight one step too high, in the next total. A two-step delay test shows subordinate spikes from two ticks back completing a fire. A design that delayed the gating input as well would never evaluate, and one that ignored the delay would miss the threshold.

// File: rtl/neuron_pkg.sv
`timescale 1ns/1ps
package neuron_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_ACCUM   = 2'd1,
      ST_COMPARE = 2'd2,
      ST_UPDATE  = 2'd3
   } nrn_state_e;
endpackage

// File: rtl/spike_delay_line.sv
`timescale 1ns/1ps
module spike_delay_line #(
   parameter int NS   = 3,
   parameter int DMAX = 7,
   parameter int DW   = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic [NS-1:0] din,
   input  logic [DW-1:0] dly,
   output logic [NS-1:0] dout
);
   generate
      if (DMAX == 0) begin : g_nodelay
         assign dout = din;
      end else begin : g_delay
         logic [NS-1:0] hist_q [1:DMAX];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 1; k <= DMAX; k++) hist_q[k] <= '0;
            end else if (tick) begin
               hist_q[1] <= din;
               for (int k = 2; k <= DMAX; k++) hist_q[k] <= hist_q[k-1];
            end
         end
         always_comb begin
            dout = din;
            for (int k = 1; k <= DMAX; k++)
               if (int'(dly) == k) dout = hist_q[k];
            if (int'(dly) > DMAX) dout = hist_q[DMAX];
         end
      end
   endgenerate
endmodule

// File: rtl/synapse_bank.sv
`timescale 1ns/1ps
module synapse_bank #(
   parameter int N_SYN    = 4,
   parameter int W        = 16,
   parameter int INC_STEP = 64,
   parameter int DEC_STEP = 32,
   localparam int IDXW    = $clog2(N_SYN)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     upd_en,
   input  logic [IDXW-1:0]          upd_idx,
   input  logic                     upd_hit,
   input  logic [W-1:0]             disc_level,
   input  logic                     conn_req,
   input  logic [IDXW-1:0]          conn_idx,
   input  logic [W-1:0]             conn_weight,
   output logic [N_SYN-1:0][W-1:0]  weight,
   output logic [N_SYN-1:0]         linked
);
   localparam logic [W:0]   INC_EXT = (W+1)'(INC_STEP);
   localparam logic [W-1:0] DEC_VAL = W'(DEC_STEP);

   for (genvar i = 0; i < N_SYN; i++) begin : g_syn
      logic [W:0]   up_raw;
      logic [W-1:0] next_w;
      always_comb begin
         up_raw = {1'b0, weight[i]} + INC_EXT;
         if (upd_hit)
            next_w = up_raw[W] ? {W{1'b1}} : up_raw[W-1:0];
         else
            next_w = (weight[i] < DEC_VAL) ? '0 : weight[i] - DEC_VAL;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            weight[i] <= '0;
            linked[i] <= 1'b0;
         end else begin
            if (upd_en && (upd_idx == IDXW'(i)) && linked[i]) begin
               weight[i] <= next_w;
               if (next_w < disc_level) linked[i] <= 1'b0;
            end
            if (conn_req && (conn_idx == IDXW'(i))) begin
               weight[i] <= conn_weight;
               linked[i] <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/neuron_eval.sv
`timescale 1ns/1ps
module neuron_eval
   import neuron_pkg::*;
#(
   parameter int N_SYN = 4,
   parameter int W     = 16,
   localparam int IDXW = $clog2(N_SYN),
   localparam int SUMW = W + IDXW,
   localparam int CMPW = SUMW + 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     tick,
   input  logic                     master,
   input  logic [N_SYN-2:0]         slaves,
   input  logic [N_SYN-1:0][W-1:0]  weight,
   input  logic [N_SYN-1:0]         linked,
   output logic                     upd_en,
   output logic [IDXW-1:0]          upd_idx,
   output logic                     upd_hit,
   output logic                     fire,
   output logic                     busy,
   output logic [SUMW-1:0]          dbg_fired_sum,
   output logic [SUMW-1:0]          dbg_total_sum
);
   localparam logic [IDXW-1:0] LAST = IDXW'(N_SYN - 1);

   nrn_state_e      state_q;
   logic [N_SYN-1:0] smp_q;
   logic [IDXW-1:0] idx_q;
   logic [SUMW-1:0] acc_f_q, acc_t_q;
   logic            win;

   assign win     = (CMPW'(acc_f_q) * CMPW'(10)) > (CMPW'(acc_t_q) * CMPW'(9));
   assign busy    = (state_q != ST_IDLE);
   assign upd_en  = (state_q == ST_UPDATE);
   assign upd_idx = idx_q;
   assign upd_hit = smp_q[idx_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= ST_IDLE;
         smp_q         <= '0;
         idx_q         <= '0;
         acc_f_q       <= '0;
         acc_t_q       <= '0;
         fire          <= 1'b0;
         dbg_fired_sum <= '0;
         dbg_total_sum <= '0;
      end else begin
         fire <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (tick && master) begin
                  smp_q   <= {slaves, master};
                  idx_q   <= '0;
                  acc_f_q <= '0;
                  acc_t_q <= '0;
                  state_q <= ST_ACCUM;
               end
            end
            ST_ACCUM: begin
               if (linked[idx_q]) begin
                  acc_t_q <= acc_t_q + SUMW'(weight[idx_q]);
                  if (smp_q[idx_q]) acc_f_q <= acc_f_q + SUMW'(weight[idx_q]);
               end
               if (idx_q == LAST) state_q <= ST_COMPARE;
               else               idx_q   <= idx_q + 1'b1;
            end
            ST_COMPARE: begin
               dbg_fired_sum <= acc_f_q;
               dbg_total_sum <= acc_t_q;
               fire          <= win;
               idx_q         <= '0;
               state_q       <= win ? ST_UPDATE : ST_IDLE;
            end
            ST_UPDATE: begin
               if (idx_q == LAST) state_q <= ST_IDLE;
               else               idx_q   <= idx_q + 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/spiking_neuron_core.sv
`timescale 1ns/1ps
module spiking_neuron_core #(
   parameter int N_SYN    = 4,
   parameter int W        = 16,
   parameter int INC_STEP = 64,
   parameter int DEC_STEP = 32,
   parameter int DLY_MAX  = 7,
   localparam int IDXW    = $clog2(N_SYN),
   localparam int SUMW    = W + IDXW,
   localparam int DLYW    = (DLY_MAX > 0) ? $clog2(DLY_MAX + 1) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [N_SYN-1:0]  spike_in,
   input  logic [DLYW-1:0]   slave_delay,
   input  logic [W-1:0]      disc_level,
   input  logic              conn_req,
   input  logic [IDXW-1:0]   conn_idx,
   input  logic [W-1:0]      conn_weight,
   output logic              fire,
   output logic              busy,
   output logic [SUMW-1:0]   dbg_fired_sum,
   output logic [SUMW-1:0]   dbg_total_sum
);
   if (N_SYN < 2) begin : g_bad_nsyn
      $error("spiking_neuron_core: N_SYN must be at least 2");
   end
   if (INC_STEP < 1 || DEC_STEP < 1 || INC_STEP >= (1 << W) || DEC_STEP >= (1 << W)) begin : g_bad_step
      $error("spiking_neuron_core: step sizes must lie in 1..2**W-1");
   end

   logic [N_SYN-2:0]         slaves_dly;
   logic [N_SYN-1:0][W-1:0]  weight;
   logic [N_SYN-1:0]         linked;
   logic                     upd_en, upd_hit;
   logic [IDXW-1:0]          upd_idx;

   spike_delay_line #(.NS(N_SYN-1), .DMAX(DLY_MAX), .DW(DLYW)) u_dly (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .din(spike_in[N_SYN-1:1]), .dly(slave_delay), .dout(slaves_dly)
   );

   synapse_bank #(.N_SYN(N_SYN), .W(W), .INC_STEP(INC_STEP), .DEC_STEP(DEC_STEP)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .upd_en(upd_en), .upd_idx(upd_idx), .upd_hit(upd_hit),
      .disc_level(disc_level),
      .conn_req(conn_req), .conn_idx(conn_idx), .conn_weight(conn_weight),
      .weight(weight), .linked(linked)
   );

   neuron_eval #(.N_SYN(N_SYN), .W(W)) u_eval (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .master(spike_in[0]), .slaves(slaves_dly),
      .weight(weight), .linked(linked),
      .upd_en(upd_en), .upd_idx(upd_idx), .upd_hit(upd_hit),
      .fire(fire), .busy(busy),
      .dbg_fired_sum(dbg_fired_sum), .dbg_total_sum(dbg_total_sum)
   );
endmodule

// File: rtl/spiking_neuron_core_chk.sv
`timescale 1ns/1ps
module spiking_neuron_core_chk #(
   parameter int N_SYN = 4,
   parameter int W     = 16,
   localparam int IDXW = $clog2(N_SYN),
   localparam int SUMW = W + IDXW,
   localparam int CMPW = SUMW + 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic [N_SYN-1:0] spike_in,
   input logic             fire,
   input logic             busy,
   input logic [SUMW-1:0]  dbg_fired_sum,
   input logic [SUMW-1:0]  dbg_total_sum
);
   AST_FIRE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire); // R4
   AST_FIRE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> $past(busy)); // R4
   AST_MASTER_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !busy && spike_in[0]) |=> busy); // R4
   AST_NO_MASTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !busy && !spike_in[0]) |=> !busy); // R2
   AST_SUMS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> ($stable(dbg_fired_sum) && $stable(dbg_total_sum))); // R2
   AST_FIRE_RULE: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> (CMPW'(dbg_fired_sum) * CMPW'(10) > CMPW'(dbg_total_sum) * CMPW'(9))); // R3
   AST_FIRED_LE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_fired_sum <= dbg_total_sum); // R7
endmodule

bind spiking_neuron_core spiking_neuron_core_chk #(.N_SYN(N_SYN), .W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .spike_in(spike_in),
   .fire(fire), .busy(busy),
   .dbg_fired_sum(dbg_fired_sum), .dbg_total_sum(dbg_total_sum)
);

// File: tb/spiking_neuron_core_tb.sv
`timescale 1ns/1ps
module spiking_neuron_core_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [3:0]  spike_in = '0;
   logic [2:0]  slave_delay = '0;
   logic [15:0] disc_level = '0;
   logic        conn_req = 1'b0;
   logic [1:0]  conn_idx = '0;
   logic [15:0] conn_weight = '0;
   logic        fire, busy;
   logic [17:0] dbg_fired_sum, dbg_total_sum;

   int n_checks = 0;
   int n_fail   = 0;
   int fire_cnt = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   spiking_neuron_core u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .spike_in(spike_in),
      .slave_delay(slave_delay), .disc_level(disc_level),
      .conn_req(conn_req), .conn_idx(conn_idx), .conn_weight(conn_weight),
      .fire(fire), .busy(busy),
      .dbg_fired_sum(dbg_fired_sum), .dbg_total_sum(dbg_total_sum)
   );

   always @(negedge clk) if (rst_n && fire) fire_cnt++;

   typedef struct packed {
      logic        cen;
      logic [1:0]  cidx;
      logic [15:0] cw;
      logic [3:0]  spk;
      logic        efire;
      logic [17:0] ef;
      logic [17:0] et;
   } vec_t;

   // Weights start at 1000 on all four synapses, floor 80, no delay.
   localparam vec_t VECS [9] = '{
      '{1'b0, 2'd0, 16'd0,    4'b1111, 1'b1, 18'd4000, 18'd4000}, // R3 R5
      '{1'b0, 2'd0, 16'd0,    4'b1110, 1'b0, 18'd4000, 18'd4000}, // R2
      '{1'b0, 2'd0, 16'd0,    4'b0111, 1'b0, 18'd3192, 18'd4256}, // R3 R5
      '{1'b0, 2'd0, 16'd0,    4'b1111, 1'b1, 18'd4256, 18'd4256}, // R5
      '{1'b1, 2'd3, 16'd100,  4'b0111, 1'b1, 18'd3384, 18'd3484}, // R8 R5
      '{1'b0, 2'd0, 16'd0,    4'b1111, 1'b1, 18'd3576, 18'd3576}, // R7
      '{1'b0, 2'd0, 16'd0,    4'b0001, 1'b0, 18'd1256, 18'd3768}, // R3 R7
      '{1'b1, 2'd3, 16'd1000, 4'b1111, 1'b1, 18'd4768, 18'd4768}, // R8
      '{1'b0, 2'd0, 16'd0,    4'b1011, 1'b0, 18'd3704, 18'd5024}  // R5
   };

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; tick = 1'b0; spike_in = '0; conn_req = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic connect(input logic [1:0] idx, input logic [15:0] w);
      @(negedge clk);
      conn_req = 1'b1; conn_idx = idx; conn_weight = w;
      @(negedge clk);
      conn_req = 1'b0;
   endtask

   task automatic step(input logic [3:0] spk);
      @(negedge clk);
      tick = 1'b1; spike_in = spk;
      @(negedge clk);
      tick = 1'b0; spike_in = '0;
      repeat (16) @(negedge clk);
   endtask

   initial begin
      int f0;
      do_reset();
      // R1: reset state
      chk("R1 fire", fire, 0);
      chk("R1 busy", busy, 0);
      chk("R1 fired_sum", dbg_fired_sum, 0);
      chk("R1 total_sum", dbg_total_sum, 0);
      f0 = fire_cnt;
      step(4'b1111);
      chk("R1 no fire when nothing connected", fire_cnt - f0, 0);
      chk("R1 total with nothing connected", dbg_total_sum, 0);

      // Vector table
      disc_level = 16'd80;
      for (int i = 0; i < 4; i++) connect(2'(i), 16'd1000);
      for (int v = 0; v < 9; v++) begin
         if (VECS[v].cen) connect(VECS[v].cidx, VECS[v].cw);
         f0 = fire_cnt;
         step(VECS[v].spk);
         chk($sformatf("R3/R5/R7 vec%0d fire", v), fire_cnt - f0, int'(VECS[v].efire));
         chk($sformatf("R2/R5 vec%0d fired_sum", v), dbg_fired_sum, int'(VECS[v].ef));
         chk($sformatf("R7/R8 vec%0d total_sum", v), dbg_total_sum, int'(VECS[v].et));
      end

      // R4: busy and fire timing (weights now 1320,1320,1320,1064)
      @(negedge clk);
      tick = 1'b1; spike_in = 4'b1111;
      @(negedge clk);
      tick = 1'b0; spike_in = '0;
      chk("R4 busy after tick", busy, 1);
      repeat (4) @(negedge clk);
      chk("R4 fire not early", fire, 0);
      @(negedge clk);
      chk("R4 fire in fifth cycle", fire, 1);
      @(negedge clk);
      chk("R4 fire one cycle", fire, 0);
      repeat (4) @(negedge clk);
      chk("R4 busy released", busy, 0);
      repeat (6) @(negedge clk);

      // R9: connect collides with learning write of synapse 2
      do_reset();
      disc_level = 16'd80;
      for (int i = 0; i < 4; i++) connect(2'(i), 16'd1000);
      @(negedge clk);
      tick = 1'b1; spike_in = 4'b1111;
      @(negedge clk);
      tick = 1'b0; spike_in = '0;
      repeat (7) @(negedge clk);
      conn_req = 1'b1; conn_idx = 2'd2; conn_weight = 16'd500;
      @(negedge clk);
      conn_req = 1'b0;
      repeat (10) @(negedge clk);
      step(4'b1111);
      chk("R9 connect wins over update", dbg_total_sum, 3692);

      // R3: exact nine-tenths boundary
      do_reset();
      disc_level = 16'd0;
      connect(2'd0, 16'd900);
      connect(2'd1, 16'd100);
      f0 = fire_cnt;
      step(4'b0001);
      chk("R3 exact 90% no fire", fire_cnt - f0, 0);
      chk("R3 boundary fired_sum", dbg_fired_sum, 900);
      connect(2'd0, 16'd901);
      f0 = fire_cnt;
      step(4'b0001);
      chk("R3 just above 90% fires", fire_cnt - f0, 1);

      // R6: saturation at both ends
      do_reset();
      disc_level = 16'd0;
      connect(2'd0, 16'hFFF0);
      connect(2'd1, 16'd10);
      f0 = fire_cnt;
      step(4'b0001);
      chk("R6 first fire", fire_cnt - f0, 1);
      step(4'b0001);
      chk("R6 increase saturates", dbg_fired_sum, 65535);
      chk("R6 decrease saturates", dbg_total_sum, 65535);

      // R10: subordinate delay of two ticks, gating input undelayed
      do_reset();
      disc_level = 16'd80;
      slave_delay = 3'd2;
      for (int i = 0; i < 4; i++) connect(2'(i), 16'd1000);
      step(4'b1110);
      step(4'b0000);
      f0 = fire_cnt;
      step(4'b0001);
      chk("R10 delayed spikes fire", fire_cnt - f0, 1);
      chk("R10 delayed fired_sum", dbg_fired_sum, 4000);
      slave_delay = 3'd0;

      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule